// File: doc/BRIEF.md
# 16-bit Ethernet client transmit sequencer

This block sits between a byte-wide frame source and the 16-bit transmit client port of an Ethernet MAC. It takes bytes one client clock at a time through a valid/ready handshake and packs them into 16-bit words. It presents the words at half the client clock rate, so one word cycle lasts two clock cycles. There are two valid strobes: one covers the whole word and one covers only the upper byte lane. When a frame has an odd length, its last word carries a single byte, and the upper strobe is low for that word.

A frame opens with its first two bytes, the first two destination-address bytes, on the bus. Both strobes are high and a first-word marker is raised. That word holds until the MAC acknowledges it. After the acknowledge, one word follows per word cycle with no pauses. Between back-to-back frames, both strobes drop for exactly one word cycle, which is a two-byte gap. If the source runs dry partway through a frame after the acknowledge, the block flags an underrun for one word cycle, stops driving the frame and discards the source's remaining bytes of that frame. Frames must be at least two bytes long.

Top module: `eth_tx16_seq`

## Requirements
- R1: Reset is synchronous and active high. After reset is released, the word outputs (tx_data, tx_dv, tx_dv_hi, tx_first, tx_underrun) change only on every second rising clock edge, starting with the second edge after reset. Each output value therefore lasts one word cycle of two clocks.
- R2: In every valid word, tx_data[7:0] carries the earlier byte of the pair and tx_data[15:8] carries the byte that followed it in the source stream.
- R3: Every word of an even-length frame, the last word included, has both tx_dv and tx_dv_hi high.
- R4: The last word of an odd-length frame has tx_dv high, tx_dv_hi low and tx_data[15:8] at zero. tx_dv_hi is never high while tx_dv is low.
- R5: The first word of each frame carries source bytes 0 and 1 with both strobes high, and tx_first is high only during that word.
- R6: The first word stays unchanged until mac_ack has been high on a clock edge inside a word cycle. The second word appears at the next word boundary. From then on a new word appears every word cycle until the frame ends.
- R7: When the next frame's first two bytes are already available, exactly one word cycle with both strobes low separates the last word of a frame from the first word of the next.
- R8: If the source has no byte to fill the next word after the acknowledge, tx_underrun is high for exactly one word cycle with both strobes low. The source's remaining bytes of that frame, through the one marked last, are accepted and dropped, and the next frame is sent intact.
- R9: Whenever tx_dv is low, tx_data is zero and tx_dv_hi is low.
- R10: While rst is high, tx_dv, tx_dv_hi, tx_first and tx_underrun are low and tx_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Client clock; one word cycle spans two periods |
| rst | input | 1 | Synchronous active-high reset |
| src_data | input | 8 | Frame byte from the source |
| src_valid | input | 1 | Source byte is valid |
| src_last | input | 1 | Source byte is the final byte of its frame |
| src_ready | output | 1 | Block accepts the source byte this clock |
| mac_ack | input | 1 | MAC has taken the first word of the frame |
| tx_data | output | 16 | Word to the MAC, earlier byte in the low lane |
| tx_dv | output | 1 | Whole-word valid strobe |
| tx_dv_hi | output | 1 | Upper-byte valid strobe |
| tx_first | output | 1 | Word holds the first two destination-address bytes |
| tx_underrun | output | 1 | Frame aborted because the source ran dry |

## Verification
Frames of every length from two to nine bytes are sent back to back, once each with an acknowledge delay of zero, one and two word cycles. Odd and even lengths separate the single-byte closing word from the full one. The two-byte frame tests a first word that is also the last. The different delays show that the first word is held exactly until the acknowledge and is not released early or late. A final ten-byte frame stalls at its fifth byte, which isolates the underrun path and the discarding of the remaining bytes. A normal frame after it shows that sending recovers cleanly.

// File: rtl/eth_tx16_seq.sv
module eth_tx16_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  src_data,
  input  logic        src_valid,
  input  logic        src_last,
  output logic        src_ready,
  input  logic        mac_ack,
  output logic [15:0] tx_data,
  output logic        tx_dv,
  output logic        tx_dv_hi,
  output logic        tx_first,
  output logic        tx_underrun
);

  logic        phase, sending, out_last, ack_seen, drop_r;
  logic [15:0] stg, stg_n;
  logic [1:0]  stg_cnt, cnt_n;
  logic        stg_end, end_n;

  wire wb   = phase;
  assign src_ready = drop_r | (stg_cnt != 2'd2 && !stg_end);
  wire take = src_valid & src_ready & !drop_r;

  always_comb begin
    stg_n = stg;
    cnt_n = stg_cnt;
    end_n = stg_end;
    if (take) begin
      if (stg_cnt == 2'd0) stg_n[7:0] = src_data;
      else                 stg_n[15:8] = src_data;
      cnt_n = stg_cnt + 2'd1;
      end_n = src_last;
    end
  end

  wire word_rdy = (cnt_n == 2'd2) || end_n;
  wire hold     = tx_first & !(ack_seen | mac_ack);
  wire adv      = sending & !hold & !out_last;
  wire load     = wb & word_rdy & (!sending | adv);
  wire under    = wb & adv & !word_rdy;
  wire finish   = wb & sending & !hold & out_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= 1'b0;
      sending     <= 1'b0;
      out_last    <= 1'b0;
      ack_seen    <= 1'b0;
      drop_r      <= 1'b0;
      stg         <= '0;
      stg_cnt     <= '0;
      stg_end     <= 1'b0;
      tx_data     <= '0;
      tx_dv       <= 1'b0;
      tx_dv_hi    <= 1'b0;
      tx_first    <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      phase <= ~phase;

      if (load | under) begin
        stg     <= '0;
        stg_cnt <= '0;
        stg_end <= 1'b0;
      end else begin
        stg     <= stg_n;
        stg_cnt <= cnt_n;
        stg_end <= end_n;
      end

      if (under)
        drop_r <= 1'b1;
      else if (drop_r && src_valid && src_last)
        drop_r <= 1'b0;

      if (wb)
        ack_seen <= 1'b0;
      else if (sending && tx_first && mac_ack)
        ack_seen <= 1'b1;

      if (wb)
        tx_underrun <= under;

      if (load) begin
        tx_data  <= {(cnt_n == 2'd2) ? stg_n[15:8] : 8'h00, stg_n[7:0]};
        tx_dv    <= 1'b1;
        tx_dv_hi <= (cnt_n == 2'd2);
        tx_first <= !sending;
        out_last <= end_n;
        sending  <= 1'b1;
      end else if (under | finish) begin
        tx_data  <= '0;
        tx_dv    <= 1'b0;
        tx_dv_hi <= 1'b0;
        tx_first <= 1'b0;
        out_last <= 1'b0;
        sending  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/eth_tx16_seq_chk.sv
module eth_tx16_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        mac_ack,
  input logic [15:0] tx_data,
  input logic        tx_dv,
  input logic        tx_dv_hi,
  input logic        tx_first,
  input logic        tx_underrun
);

  AST_WORD_RATE: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_dv) |=> $stable(tx_dv)); // R1
  AST_HI_NEEDS_DV: assert property (@(posedge clk) disable iff (rst)
    tx_dv_hi |-> tx_dv); // R4
  AST_FIRST_FULL: assert property (@(posedge clk) disable iff (rst)
    tx_first |-> (tx_dv && tx_dv_hi)); // R5
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (rst)
    (tx_first && $past(tx_first)) |-> $stable(tx_data)); // R6
  AST_GAP_WORD: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_dv) |=> !tx_dv); // R7
  AST_UNDR_IDLE: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |-> !tx_dv); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !tx_dv |-> (tx_data == 16'h0 && !tx_dv_hi)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!tx_dv && !tx_first && !tx_underrun && tx_data == 16'h0)); // R10

endmodule

bind eth_tx16_seq eth_tx16_seq_chk chk_i (
  .clk(clk), .rst(rst), .mac_ack(mac_ack), .tx_data(tx_data), .tx_dv(tx_dv),
  .tx_dv_hi(tx_dv_hi), .tx_first(tx_first), .tx_underrun(tx_underrun)
);

// File: tb/eth_tx16_seq_tb.sv
module eth_tx16_seq_tb_top;

  localparam int NF  = 26;
  localparam int UF  = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src_data;
  logic        src_valid, src_last, src_ready;
  logic        mac_ack = 1'b0;
  logic [15:0] tx_data;
  logic        tx_dv, tx_dv_hi, tx_first, tx_underrun;

  always #5 clk = ~clk;

  eth_tx16_seq dut_i (
    .clk(clk), .rst(rst), .src_data(src_data), .src_valid(src_valid),
    .src_last(src_last), .src_ready(src_ready), .mac_ack(mac_ack),
    .tx_data(tx_data), .tx_dv(tx_dv), .tx_dv_hi(tx_dv_hi),
    .tx_first(tx_first), .tx_underrun(tx_underrun)
  );

  int lens [NF];
  int dly  [NF];
  logic [7:0] mem  [256];
  logic       lastm[256];
  int tot, stall_idx;
  logic stall = 1'b1;
  int ptr;
  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int cur_f = 0, pos = 0, hold = 0, idle = 0, under_n = 0;
  bit skip_gap = 1'b0, done = 1'b0;
  logic [19:0] snap;

  function automatic logic [7:0] bval(int f, int i);
    return 8'((f * 29 + i * 7 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (frame %0d)", tag, act, exp, cur_f);
    end
  endtask

  assign src_valid = (ptr < tot) && !(stall && ptr == stall_idx);
  assign src_data  = mem[ptr[7:0]];
  assign src_last  = lastm[ptr[7:0]];

  always @(posedge clk) begin
    if (rst) begin
      ptr <= 0;
      cyc <= 0;
    end else begin
      cyc <= cyc + 1;
      if (src_valid && src_ready) ptr <= ptr + 1;
    end
  end

  always @(negedge clk) begin
    mac_ack = 1'b0;
    if (rst) begin
      chk(!tx_dv && !tx_dv_hi && !tx_first && !tx_underrun && tx_data == 16'h0,
          "R10 reset outputs", {tx_dv, tx_dv_hi, tx_first, tx_underrun, tx_data}, 0);
    end else if (!done) begin
      if (cyc % 2 == 0) begin
        snap = {tx_data, tx_dv, tx_dv_hi, tx_first, tx_underrun};
      end else begin
        if (cyc > 1)
          chk(snap == {tx_data, tx_dv, tx_dv_hi, tx_first, tx_underrun},
              "R1 word held two clocks", {tx_data, tx_dv, tx_dv_hi, tx_first, tx_underrun}, snap);
        if (tx_underrun) begin
          under_n++;
          chk(!tx_dv && !tx_dv_hi, "R8 strobes low on underrun", {tx_dv, tx_dv_hi}, 0);
          chk(cur_f == UF && pos == 4, "R8 underrun point", cur_f * 100 + pos, UF * 100 + 4);
          cur_f++; pos = 0; hold = 0; idle = 0; skip_gap = 1'b1; stall = 1'b0;
        end else if (tx_dv) begin
          int p, rem;
          logic [7:0] elo, ehi;
          if (tx_first) begin
            if (hold == 0) begin
              if (cur_f > 0 && !skip_gap) chk(idle == 1, "R7 gap words", idle, 1);
              skip_gap = 1'b0;
            end
            hold++;
            if (hold == dly[cur_f] + 1) mac_ack = 1'b1;
            p = 0;
          end else begin
            if (pos == 0) begin
              chk(hold == dly[cur_f] + 1, "R6 first word hold", hold, dly[cur_f] + 1);
              pos = 2;
            end
            p = pos;
          end
          rem = lens[cur_f] - p;
          elo = bval(cur_f, p);
          ehi = (rem >= 2) ? bval(cur_f, p + 1) : 8'h00;
          chk(tx_first == (p == 0), "R5 first marker", tx_first, p == 0);
          if (rem >= 2) chk(tx_dv_hi, "R3 upper strobe on full word", tx_dv_hi, 1);
          else          chk(!tx_dv_hi, "R4 upper strobe low on odd end", tx_dv_hi, 0);
          chk(tx_data == {ehi, elo}, "R2 byte lanes", tx_data, {ehi, elo});
          if (!tx_first) begin
            pos += 2;
            if (pos >= lens[cur_f]) begin
              cur_f++; pos = 0; hold = 0; idle = 0;
            end
          end
        end else begin
          if (hold > 0) begin
            chk(hold == dly[cur_f] + 1, "R6 first word hold", hold, dly[cur_f] + 1);
            cur_f++; pos = 0; hold = 0; idle = 0;
          end
          if (pos > 0) chk(1'b0, "R6 stall inside frame", 0, 1);
          idle++;
          chk(tx_data == 16'h0 && !tx_dv_hi, "R9 idle bus", {tx_dv_hi, tx_data}, 0);
        end
      end
    end
  end

  initial begin
    int a;
    a = 0;
    for (int f = 0; f < NF; f++) begin
      if (f < UF)       begin lens[f] = 2 + (f % 8); dly[f] = f / 8; end
      else if (f == UF) begin lens[f] = 10; dly[f] = 0; end
      else              begin lens[f] = 5; dly[f] = 1; end
      if (f == UF) stall_idx = a + 4;
      for (int i = 0; i < lens[f]; i++) begin
        mem[a]   = bval(f, i);
        lastm[a] = (i == lens[f] - 1);
        a++;
      end
    end
    for (int k = a; k < 256; k++) begin mem[k] = 8'h00; lastm[k] = 1'b0; end
    tot = a;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int t = 0; t < 20000 && cur_f < NF; t++) @(posedge clk);
    repeat (8) @(posedge clk);
    done = 1'b1;
    chk(cur_f == NF, "R8 all frames seen (watchdog)", cur_f, NF);
    chk(under_n == 1, "R8 single underrun word", under_n, 1);
    chk(ptr == tot, "R8 dropped bytes drained", ptr, tot);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule